// File: doc/BRIEF.md
# Keyboard Wake Interrupt Controller

This block watches eight keyboard input pins and raises one interrupt flag when the group of enabled pins leaves the idle state in which every enabled pin is high. Every pin passes through a two-flop synchronizer. The enabled, synchronized pins are then ANDed into a single idle signal. The flag latches on the falling edge of that combined signal. Because of this, one pin that is still held low hides a new press on another pin.

A mode bit selects one of two clearing rules. In edge mode, an acknowledge clears the flag. In level mode, the flag also stays set while any enabled pin is low, and it clears only after both an acknowledge and a return of all enabled pins to high. Those two events may happen in either order. An acknowledge comes from the CPU vector-fetch strobe or from a software write. A mask bit stops the flag from reaching the CPU interrupt line. Each enabled pin also drives its own pull-up request.

Top module: `kbd_wake_irq`

## Requirements
- R1: A pin whose enable bit is 0 has no effect on the flag, whatever its level or transitions.
- R2: `pullup_en[i]` equals the enable bit of pin i at all times, and does not depend on any other setting.
- R3: The flag sets when the AND of the enabled, synchronized pins goes from 1 to 0. A pin driven low before clock edge k gives a flag of 1 after edge k+2.
- R4: In edge mode (control bit 0 = 0), a falling pin does not set the flag while another enabled pin is already low.
- R5: In level mode (control bit 0 = 1), an acknowledge does not clear the flag while any enabled pin is low.
- R6: In edge mode, an acknowledge clears the flag at the next edge. If an acknowledge and a new falling edge of the AND fall in the same cycle, the flag is set.
- R7: In level mode, the flag clears once both an acknowledge has been given and all enabled pins are high, in either order, and not before both.
- R8: An acknowledge does not block later input changes: a falling edge after an acknowledge sets the flag again.
- R9: `irq` equals the flag when the mask (control bit 1) is 0, and is 0 when the mask is 1. The flag still latches while masked.
- R10: Register map. Address 0 is control: bit0 mode, bit1 mask, bit2 acknowledge (a write of 1 strobes it, it reads 0), bit3 flag (read-only). Address 1 holds the eight enable bits. After reset, all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_in | input | 8 | Asynchronous keyboard pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 control, 1 enables) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Read data, combinational |
| vec_ack | input | 1 | CPU vector-fetch acknowledge strobe |
| pullup_en | output | 8 | Per-pin pull-up request |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The case that needs care is an acknowledge landing in the same cycle as a new falling edge of the combined pin signal. The bench drives a pin low and then raises `vec_ack` exactly two edges later, so that the acknowledge is sampled in the very cycle the synchronized fall reaches the flag. The flag must read 1 afterwards. A control run with the acknowledge and no edge must read 0. Level-mode clearing is checked with the acknowledge placed both before and after the pin release.

// File: rtl/kbd_wake_irq.sv
module kbd_wake_irq #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] key_in,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             rd_addr,
  output logic [7:0]       rd_data,
  input  logic             vec_ack,
  output logic [NPINS-1:0] pullup_en,
  output logic             irq
);
  localparam logic [NPINS-1:0] ALL1 = '1;

  logic [NPINS-1:0] s1, s2, en;
  logic mode, mask, flag, ack_seen, prev_and;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= ALL1;
      s2 <= ALL1;
    end else begin
      s1 <= key_in;
      s2 <= s1;
    end

  wire and_cur = &(s2 | ~en);
  wire fall    = prev_and & ~and_cur;
  wire wr_ctl  = wr_en & ~wr_addr;
  wire ack     = vec_ack | (wr_ctl & wr_data[2]);
  wire lvl_clr = flag & (ack | ack_seen) & and_cur;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en       <= '0;
      mode     <= 1'b0;
      mask     <= 1'b0;
      prev_and <= 1'b1;
      flag     <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      if (wr_en && wr_addr) en <= wr_data[NPINS-1:0];
      if (wr_ctl) begin
        mode <= wr_data[0];
        mask <= wr_data[1];
      end
      prev_and <= and_cur;
      if (fall) begin
        flag     <= 1'b1;
        ack_seen <= 1'b0;
      end else if (!mode) begin
        ack_seen <= 1'b0;
        if (ack) flag <= 1'b0;
      end else if (lvl_clr) begin
        flag     <= 1'b0;
        ack_seen <= 1'b0;
      end else if (ack && flag) begin
        ack_seen <= 1'b1;
      end
    end

  assign pullup_en = en;
  assign irq       = flag & ~mask;
  assign rd_data   = rd_addr ? 8'(en) : {4'b0, flag, 1'b0, mask, mode};
endmodule

module kbd_wake_irq_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode,
  input logic             mask,
  input logic             flag,
  input logic             irq,
  input logic             ack,
  input logic             fall,
  input logic             and_cur,
  input logic [NPINS-1:0] en
);
  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);
  a_r6_edge_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && ack && !fall) |=> !flag);
  a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && flag && !and_cur && !fall) |=> flag);
  a_r3_set_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(fall));
  a_r1_no_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !$rose(flag));
endmodule

bind kbd_wake_irq kbd_wake_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .mask(mask), .flag(flag),
  .irq(irq), .ack(ack), .fall(fall), .and_cur(and_cur), .en(en)
);

// File: tb/tb_kbd_wake_irq.sv
module tb_kbd_wake_irq;
  logic clk = 0, rst_n = 0;
  logic [7:0] key_in = 8'hFF, wr_data = 0, rd_data, pullup_en;
  logic wr_en = 0, wr_addr = 0, rd_addr = 0, vec_ack = 0, irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kbd_wake_irq dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic flag_rd();
    return rd_data[3];
  endfunction

  task automatic rd_flag(output logic f);
    rd_addr = 0; #1 f = rd_data[3];
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic f;
    waitn(2); rst_n = 1; waitn(1);
    rd_addr = 0; #1 chk("R10 ctrl reset", rd_data, 8'h00);
    rd_addr = 1; #1 chk("R10 enable reset", rd_data, 8'h00);
    chk("R10 irq reset", {7'b0, irq}, 8'h00);

    key_in = 8'h00; waitn(4); rd_flag(f);
    chk("R1 disabled pins", {7'b0, f}, 8'h00);
    key_in = 8'hFF; waitn(4);

    for (int e = 0; e < 256; e += 7) begin
      wr(1, 8'(e));
      chk("R2 pullup", pullup_en, 8'(e));
      for (int p = 0; p < 8; p++) begin
        key_in = 8'hFF; waitn(3); wr(0, 8'h04);
        key_in = ~(8'h01 << p); waitn(3); rd_flag(f);
        chk("R3 flag on fall", {7'b0, f}, {7'b0, e[p]});
        chk("R9 irq follows flag", {7'b0, irq}, {7'b0, e[p]});
      end
    end
    key_in = 8'hFF; waitn(3); wr(0, 8'h04);

    wr(1, 8'h03);
    key_in = 8'hFE; waitn(3); rd_flag(f);
    chk("R3 pin0 sets", {7'b0, f}, 8'h01);
    wr(0, 8'h04); rd_flag(f);
    chk("R6 ack clears", {7'b0, f}, 8'h00);
    key_in = 8'hFC; waitn(4); rd_flag(f);
    chk("R4 masked by low pin", {7'b0, f}, 8'h00);
    key_in = 8'hFF; waitn(3);
    key_in = 8'hFD; waitn(3); rd_flag(f);
    chk("R8 new fall after ack", {7'b0, f}, 8'h01);
    rd_addr = 0; #1 chk("R10 ack reads 0", rd_data & 8'h04, 8'h00);

    wr(0, 8'h02); rd_flag(f);
    chk("R9 masked flag kept", {7'b0, f}, 8'h01);
    chk("R9 masked irq", {7'b0, irq}, 8'h00);
    wr(0, 8'h00);
    chk("R9 unmasked irq", {7'b0, irq}, 8'h01);
    key_in = 8'hFF; waitn(3); wr(0, 8'h04);

    key_in = 8'hFE;
    waitn(2); vec_ack = 1; waitn(1); vec_ack = 0; rd_flag(f);
    chk("R6 set wins over ack", {7'b0, f}, 8'h01);
    vec_ack = 1; waitn(1); vec_ack = 0; rd_flag(f);
    chk("R6 vector ack clears", {7'b0, f}, 8'h00);
    key_in = 8'hFF; waitn(3);

    wr(0, 8'h01);
    key_in = 8'hFE; waitn(3); rd_flag(f);
    chk("R3 level set", {7'b0, f}, 8'h01);
    wr(0, 8'h05); rd_flag(f);
    chk("R5 ack while low keeps", {7'b0, f}, 8'h01);
    waitn(2); rd_flag(f);
    chk("R5 still held", {7'b0, f}, 8'h01);
    key_in = 8'hFF; waitn(3); rd_flag(f);
    chk("R7 ack then release clears", {7'b0, f}, 8'h00);

    key_in = 8'hFD; waitn(3);
    key_in = 8'hFF; waitn(4); rd_flag(f);
    chk("R7 release alone keeps", {7'b0, f}, 8'h01);
    vec_ack = 1; waitn(1); vec_ack = 0; rd_flag(f);
    chk("R7 release then ack clears", {7'b0, f}, 8'h00);

    wr(1, 8'h00); key_in = 8'h00; waitn(4); rd_flag(f);
    chk("R1 level mode disabled", {7'b0, f}, 8'h00);
    chk("R2 pullup off", pullup_en, 8'h00);

    finish_run();
  end
endmodule